// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a single clocked register meant to sit on the boundary between two pieces of combinational logic. A two-bit mode input decides, cycle by cycle, what the register does with its next clock edge. It can capture functional data like an ordinary pipeline register, or run as a maximal-length pseudo-random pattern source that drives the logic downstream. It can also fold the responses arriving from the logic upstream into a compact signature, or act as one segment of a serial scan chain.

A typical self-test pass places the register in pattern mode on one side of a logic cloud and a second copy in signature mode on the other side. Both run for a fixed number of cycles. Both are then switched to scan mode so the signature can be shifted out through the serial pins. The logic under test and the judgement of whether a signature is correct lie outside the block.

Top module: `bist_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, the register becomes all zeros, whatever the mode. Reset is synchronous and active high.
- R2: With `mode` = 2'b00 (normal), the register loads `din` on every rising edge.
- R3: With `mode` = 2'b01 (pattern) and a nonzero state, the register shifts one place toward the MSB. Bit 0 receives the XOR of state bits 7, 5, 4 and 3, which realises the polynomial x^8+x^6+x^5+x^4+1.
- R4: With `mode` = 2'b01 and an all-zero state, the next state is the seed 8'h01.
- R5: In pattern mode, a run started from the seed 8'h01 returns to 8'h01 after exactly 255 steps and not earlier.
- R6: With `mode` = 2'b10 (signature), the next state is the pattern-mode shifted value (bits 6..0 moved up, with the same feedback bit entering bit 0) XORed bitwise with `din`. There is no seed substitution in this mode.
- R7: With `mode` = 2'b11 (scan), the register shifts one place toward the MSB and `scan_in` enters bit 0.
- R8: `scan_out` equals bit 7 of the register in every mode and every cycle.
- R9: `dout` always presents the current register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 normal, 01 pattern, 10 signature, 11 scan |
| din | input | 8 | Parallel data or response input |
| scan_in | input | 1 | Serial input, enters bit 0 in scan mode |
| dout | output | 8 | Parallel register contents |
| scan_out | output | 1 | Serial output, always the MSB |

## Verification
The checker verifies the one-step behaviour of every mode on every cycle. That covers the parallel load, the upward shift in pattern, signature and scan modes, the zero-state seed substitution, the serial entry at bit 0, the reset result and the tie of the serial output to the MSB. Properties that span many cycles can only be shown by the bench's scenarios. These are the full 255-step period of the pattern sequence, the exact signature after long response streams, the order of a complete scan-out and scan-in, and a sweep of all 256 parallel values.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PRBS   = 2'b01,
        MODE_SIG    = 2'b10,
        MODE_SCAN   = 2'b11
    } bist_mode_e;

    localparam int          DEF_W    = 8;
    localparam logic [7:0]  DEF_MASK = 8'hB8;  // state bits 7,5,4,3
    localparam logic [7:0]  DEF_SEED = 8'h01;

endpackage

// File: rtl/bist_tap_xor.sv
module bist_tap_xor #(
    parameter int             W    = bist_pkg::DEF_W,
    parameter logic [W-1:0]   MASK = bist_pkg::DEF_MASK
) (
    input  logic [W-1:0] state,
    output logic         fb
);
    logic [W-1:0] terms;

    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (MASK[i]) begin : g_on
                assign terms[i] = state[i];
            end else begin : g_off
                assign terms[i] = 1'b0;
            end
        end
    endgenerate

    assign fb = ^terms;
endmodule

// File: rtl/bist_next.sv
module bist_next #(
    parameter int           W    = bist_pkg::DEF_W,
    parameter logic [W-1:0] SEED = bist_pkg::DEF_SEED
) (
    input  bist_pkg::bist_mode_e mode,
    input  logic [W-1:0]         state,
    input  logic [W-1:0]         din,
    input  logic                 scan_in,
    input  logic                 fb,
    output logic [W-1:0]         nxt
);
    import bist_pkg::*;

    logic         is_zero;
    logic [W-1:0] shifted_fb;
    logic [W-1:0] shifted_si;

    assign is_zero    = (state == '0);
    assign shifted_fb = {state[W-2:0], fb};
    assign shifted_si = {state[W-2:0], scan_in};

    always_comb begin
        unique case (mode)
            MODE_NORMAL: nxt = din;
            MODE_PRBS:   nxt = is_zero ? SEED : shifted_fb;
            MODE_SIG:    nxt = shifted_fb ^ din;
            MODE_SCAN:   nxt = shifted_si;
            default:     nxt = din;
        endcase
    end
endmodule

// File: rtl/bist_reg.sv
module bist_reg #(
    parameter int           W    = bist_pkg::DEF_W,
    parameter logic [W-1:0] MASK = bist_pkg::DEF_MASK,
    parameter logic [W-1:0] SEED = bist_pkg::DEF_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    input  logic         scan_in,
    output logic [W-1:0] dout,
    output logic         scan_out
);
    import bist_pkg::*;

    bist_mode_e   mode_e;
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic         fb;

    assign mode_e = bist_mode_e'(mode);

    bist_tap_xor #(.W(W), .MASK(MASK)) u_tap (
        .state (state_q),
        .fb    (fb)
    );

    bist_next #(.W(W), .SEED(SEED)) u_next (
        .mode    (mode_e),
        .state   (state_q),
        .din     (din),
        .scan_in (scan_in),
        .fb      (fb),
        .nxt     (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign dout     = state_q;
    assign scan_out = state_q[W-1];
endmodule

// File: rtl/bist_reg_chk.sv
module bist_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic [W-1:0] din,
    input logic         scan_in,
    input logic [W-1:0] dout,
    input logic         scan_out
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> dout == '0);

    a_r2_normal_load: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b00 |=> dout == $past(din));

    a_r3_prbs_shift: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && dout != '0) |=> dout[W-1:1] == $past(dout[W-2:0]));

    a_r4_prbs_seed: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && dout == '0) |=> dout == {{(W-1){1'b0}}, 1'b1});

    a_r6_sig_upper: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |=> dout[W-1:1] == $past(dout[W-2:0] ^ din[W-1:1]));

    a_r7_scan_entry: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b11 |=> (dout[0] == $past(scan_in)) && (dout[W-1:1] == $past(dout[W-2:0])));

    a_r8_serial_msb: assert property (@(posedge clk) disable iff (rst)
        $past(mode) == 2'b11 |-> scan_out == $past(dout[W-2]));
endmodule

bind bist_reg bist_reg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .din      (din),
    .scan_in  (scan_in),
    .dout     (dout),
    .scan_out (scan_out)
);

// File: tb/bist_reg_test.sv
module bist_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [7:0] din = 8'h00;
    logic       scan_in = 1'b0;
    logic [7:0] dout;
    logic       scan_out;

    int total = 0;
    int bad   = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;  // 50 MHz

    bist_reg uut (
        .clk(clk), .rst(rst), .mode(mode), .din(din),
        .scan_in(scan_in), .dout(dout), .scan_out(scan_out)
    );

    function automatic logic [7:0] step_model(logic [7:0] s, logic r, logic [1:0] m,
                                              logic [7:0] d, logic si);
        logic f;
        f = s[7] ^ s[5] ^ s[4] ^ s[3];
        if (r) return 8'h00;
        case (m)
            2'b00:   return d;
            2'b01:   return (s == 8'h00) ? 8'h01 : {s[6:0], f};
            2'b10:   return {s[6:0], f} ^ d;
            default: return {s[6:0], si};
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // R8: serial output tracks MSB; checked with every cycle
    task automatic cyc(logic r, logic [1:0] m, logic [7:0] d, logic si);
        logic [7:0] nxt;
        @(negedge clk);
        rst = r; mode = m; din = d; scan_in = si;
        nxt = step_model(model, r, m, d, si);
        @(posedge clk);
        #1;
        model = nxt;
        chk("R8", {7'b0, scan_out}, {7'b0, model[7]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hang exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hits;
        int first_hit;
        // R1: reset state
        cyc(1'b1, 2'b00, 8'h5A, 1'b0);
        cyc(1'b1, 2'b00, 8'h5A, 1'b0);
        chk("R1", dout, 8'h00);
        cyc(1'b0, 2'b00, 8'hC3, 1'b0);
        cyc(1'b1, 2'b01, 8'hFF, 1'b1);
        chk("R1", dout, 8'h00);

        // R2, R9: full sweep of parallel loads
        for (int v = 0; v < 256; v++) begin
            cyc(1'b0, 2'b00, 8'(v), 1'b0);
            chk("R2", dout, 8'(v));
            chk("R9", dout, model);
        end

        // R4: zero state seeds
        cyc(1'b0, 2'b00, 8'h00, 1'b0);
        cyc(1'b0, 2'b01, 8'h00, 1'b0);
        chk("R4", dout, 8'h01);

        // R3, R5: full period from the seed
        hits = 0; first_hit = 0;
        for (int k = 1; k <= 255; k++) begin
            cyc(1'b0, 2'b01, 8'hA7, 1'b1);
            chk("R3", dout, model);
            if (dout == 8'h01) begin
                hits++;
                if (first_hit == 0) first_hit = k;
            end
        end
        chk("R5", 8'(first_hit), 8'd255);
        chk("R5", 8'(hits), 8'd1);

        // R6: signature from zero and from a nonzero start
        cyc(1'b0, 2'b00, 8'h00, 1'b0);
        for (int k = 0; k < 64; k++) begin
            cyc(1'b0, 2'b10, 8'(k * 37 + 5), 1'b0);
            chk("R6", dout, model);
        end
        cyc(1'b0, 2'b00, 8'h9E, 1'b0);
        for (int k = 0; k < 64; k++) begin
            cyc(1'b0, 2'b10, 8'(k * k ^ 8'h3C), 1'b0);
            chk("R6", dout, model);
        end
        cyc(1'b0, 2'b00, 8'h00, 1'b0);
        cyc(1'b0, 2'b10, 8'h00, 1'b0);
        chk("R6", dout, 8'h00);

        // R7, R8: scan out 8'hA5 while scanning in 8'h3C
        cyc(1'b0, 2'b00, 8'hA5, 1'b0);
        for (int b = 7; b >= 0; b--) begin
            chk("R8", {7'b0, scan_out}, {7'b0, 1'((8'hA5 >> (7 - (7 - b))) & 8'h01)});
            cyc(1'b0, 2'b11, 8'hFF, 1'((8'h3C >> b) & 8'h01));
            chk("R7", dout, model);
        end
        chk("R7", dout, 8'h3C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule